// File: doc/BRIEF.md
# Synthetic Cell Traffic Generator

This block is a traffic source for one input of a switch fabric under test. In every clock cycle, treated as one cell time slot, it decides whether a cell is offered and, if so, which output port it is addressed to. A reviewer or bench uses one instance per fabric input to load the fabric with reproducible synthetic traffic. Each instance is set up through static configuration inputs that are held steady while the block runs.

Arrivals follow one of two processes. In the memoryless mode, each slot carries a cell independently with a programmable probability. In the burst mode, a two-state idle/active chain emits back-to-back cells while active and nothing while idle. It enforces a programmable minimum number of cells per burst, and all cells of one burst share one destination. Destinations are either spread evenly over the ports or skewed toward one programmable hot port with a programmable weight. All randomness comes from one 16-bit maximal-length shift register that is reseeded to a fixed value on reset.

Top module: `cell_traffic_gen`

## Requirements
- R1: While `rst_n` is low, `cell_vld` is 0 and `cell_dst` is 0, and the random register is loaded with 16'hACE1, so every run after reset yields the same sequence for the same configuration.
- R2: The random value r advances once per slot as r_next = {r[14:0], r[15]^r[13]^r[12]^r[10]}. It is never zero. The slot decision made from value r appears on the outputs in the following cycle (one register stage).
- R3: With `burst_mode`=0, a cell is emitted in a slot exactly when r < `arr_thr` (unsigned 16-bit compare).
- R4: Whenever `cell_vld` is 0, `cell_dst` is 0.
- R5: With `hot_en`=0, the destination chosen from r is r[15:8] modulo N_PORTS.
- R6: With `hot_en`=1, the destination is `hot_port` when {r[7:0], r[15:8]} < `hot_thr`; otherwise it is the uniform choice of R5.
- R7: With `burst_mode`=1 and the source idle, it becomes active when r < `on_thr`. It emits a cell in that same slot, to a destination picked from r by R5/R6.
- R8: While active, the source emits a cell every slot, and every cell of the burst carries the destination picked on entry.
- R9: An active source returns to idle, emitting no cell in that slot, only when its burst count (cells emitted in this burst) is at least `min_burst` and r < `off_thr`. A burst therefore holds at least max(`min_burst`,1) cells.
- R10: With `burst_mode`=0, `on_thr`, `off_thr` and `min_burst` have no effect, and `arr_thr`=0 yields no cells at all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_mode | input | 1 | 0 = memoryless arrivals, 1 = idle/active burst chain |
| hot_en | input | 1 | 1 = skew destinations toward `hot_port` |
| arr_thr | input | 16 | Arrival threshold for memoryless mode |
| on_thr | input | 16 | Idle-to-active threshold |
| off_thr | input | 16 | Active-to-idle threshold |
| min_burst | input | 8 | Minimum cells per burst |
| hot_port | input | 3 | Hot destination index |
| hot_thr | input | 16 | Weight of the hot destination |
| cell_vld | output | 1 | A cell is offered in this slot |
| cell_dst | output | 3 | Destination port of the offered cell |

## Verification
The memoryless mode is driven at a mid-range threshold with and without skew, to separate errors in the arrival comparison from errors in the destination choice. Saturated thresholds (zero arrivals, near-certain arrivals with a near-certain hot port) show that the comparison direction and the skewed compare are right. Burst mode is run with a long minimum burst and with a zero minimum and a near-certain exit. These two runs separate the minimum-length counter from the exit comparison, and they show the destination hold across a burst. Randomly drawn configurations then mix all the settings, and the outputs are compared slot by slot against a bench model of the random register.

// File: rtl/tgen_pkg.sv
package tgen_pkg;
  localparam int unsigned RND_W = 16;

  typedef enum logic {
    SRC_IDLE   = 1'b0,
    SRC_ACTIVE = 1'b1
  } src_state_e;
endpackage

// File: rtl/tgen_lfsr.sv
module tgen_lfsr #(
  parameter int unsigned        W    = 16,
  parameter logic [W-1:0]       SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] rnd
);
  logic [W-1:0] rnd_d;
  logic         fb;

  // Taps for x^16 + x^14 + x^13 + x^11 + 1
  always_comb begin
    fb    = rnd[W-1] ^ rnd[W-3] ^ rnd[W-4] ^ rnd[W-6];
    rnd_d = {rnd[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rnd <= SEED;
    else        rnd <= rnd_d;
  end
endmodule

// File: rtl/tgen_dest_pick.sv
module tgen_dest_pick #(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned W       = 16,
  localparam int unsigned PORT_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int unsigned HALF   = W / 2
) (
  input  logic [W-1:0]      rnd,
  input  logic              hot_en,
  input  logic [W-1:0]      hot_thr,
  input  logic [PORT_W-1:0] hot_port,
  output logic [PORT_W-1:0] dst
);
  logic [HALF-1:0] uni_full;
  logic [W-1:0]    skew_rnd;
  logic            hot_hit;

  always_comb begin
    uni_full = rnd[W-1:HALF] % HALF'(N_PORTS);
    skew_rnd = {rnd[HALF-1:0], rnd[W-1:HALF]};
    hot_hit  = hot_en && (skew_rnd < hot_thr);
    if (hot_hit) dst = hot_port;
    else         dst = uni_full[PORT_W-1:0];
  end
endmodule

// File: rtl/tgen_slot_ctl.sv
module tgen_slot_ctl
  import tgen_pkg::*;
#(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned W       = 16,
  parameter int unsigned CNT_W   = 8,
  localparam int unsigned PORT_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      rnd,
  input  logic              burst_mode,
  input  logic [W-1:0]      arr_thr,
  input  logic [W-1:0]      on_thr,
  input  logic [W-1:0]      off_thr,
  input  logic [CNT_W-1:0]  min_burst,
  input  logic [PORT_W-1:0] pick_dst,
  output logic              cell_vld,
  output logic [PORT_W-1:0] cell_dst
);
  src_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PORT_W-1:0] bdst_q, bdst_d;
  logic              bdst_en;
  logic              vld_d;
  logic [PORT_W-1:0] dst_d;
  logic [CNT_W-1:0]  cnt_inc;

  always_comb begin
    cnt_inc = (cnt_q == {CNT_W{1'b1}}) ? cnt_q : cnt_q + 1'b1;
    state_d = state_q;
    cnt_d   = cnt_q;
    bdst_d  = bdst_q;
    bdst_en = 1'b0;
    vld_d   = 1'b0;
    dst_d   = '0;
    if (!burst_mode) begin
      state_d = SRC_IDLE;
      cnt_d   = '0;
      if (rnd < arr_thr) begin
        vld_d = 1'b1;
        dst_d = pick_dst;
      end
    end else begin
      unique case (state_q)
        SRC_IDLE: begin
          if (rnd < on_thr) begin
            state_d = SRC_ACTIVE;
            cnt_d   = CNT_W'(1);
            bdst_d  = pick_dst;
            bdst_en = 1'b1;
            vld_d   = 1'b1;
            dst_d   = pick_dst;
          end
        end
        SRC_ACTIVE: begin
          if ((cnt_q >= min_burst) && (rnd < off_thr)) begin
            state_d = SRC_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_inc;
            vld_d = 1'b1;
            dst_d = bdst_q;
          end
        end
        default: state_d = SRC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SRC_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bdst_q <= '0;
    else if (bdst_en) bdst_q <= bdst_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_vld <= 1'b0;
      cell_dst <= '0;
    end else begin
      cell_vld <= vld_d;
      cell_dst <= dst_d;
    end
  end
endmodule

// File: rtl/cell_traffic_gen.sv
module cell_traffic_gen #(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned CNT_W   = 8,
  parameter logic [15:0] SEED    = 16'hACE1,
  localparam int unsigned W      = tgen_pkg::RND_W,
  localparam int unsigned PORT_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_mode,
  input  logic              hot_en,
  input  logic [W-1:0]      arr_thr,
  input  logic [W-1:0]      on_thr,
  input  logic [W-1:0]      off_thr,
  input  logic [CNT_W-1:0]  min_burst,
  input  logic [PORT_W-1:0] hot_port,
  input  logic [W-1:0]      hot_thr,
  output logic              cell_vld,
  output logic [PORT_W-1:0] cell_dst
);
  logic [W-1:0]      lfsr_q;
  logic [PORT_W-1:0] pick_dst;

  tgen_lfsr #(.W(W), .SEED(SEED)) i_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .rnd   (lfsr_q)
  );

  tgen_dest_pick #(.N_PORTS(N_PORTS), .W(W)) i_pick (
    .rnd      (lfsr_q),
    .hot_en   (hot_en),
    .hot_thr  (hot_thr),
    .hot_port (hot_port),
    .dst      (pick_dst)
  );

  tgen_slot_ctl #(.N_PORTS(N_PORTS), .W(W), .CNT_W(CNT_W)) i_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rnd        (lfsr_q),
    .burst_mode (burst_mode),
    .arr_thr    (arr_thr),
    .on_thr     (on_thr),
    .off_thr    (off_thr),
    .min_burst  (min_burst),
    .pick_dst   (pick_dst),
    .cell_vld   (cell_vld),
    .cell_dst   (cell_dst)
  );
endmodule

// File: rtl/cell_traffic_gen_chk.sv
module cell_traffic_gen_chk #(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned CNT_W   = 8,
  localparam int unsigned PORT_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              burst_mode,
  input logic [15:0]       arr_thr,
  input logic [CNT_W-1:0]  min_burst,
  input logic              cell_vld,
  input logic [PORT_W-1:0] cell_dst,
  input logic [15:0]       lfsr_q
);
  logic           pv_q;
  logic [CNT_W:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv_q <= 1'b0;
    else        pv_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   run_q <= '0;
    else if (!cell_vld)           run_q <= '0;
    else if (run_q != {(CNT_W+1){1'b1}}) run_q <= run_q + 1'b1;
  end

  p_lfsr_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 16'h0000);

  p_idle_dst_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_vld |-> cell_dst == '0);

  p_zero_thr_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pv_q && $past(!burst_mode && arr_thr == 16'h0000)) |-> !cell_vld);

  p_burst_dst_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pv_q && burst_mode && $past(burst_mode) && $past(cell_vld) && cell_vld)
      |-> cell_dst == $past(cell_dst));

  p_min_burst_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pv_q && burst_mode && $past(burst_mode) && $fell(cell_vld))
      |-> run_q >= {1'b0, min_burst});
endmodule

bind cell_traffic_gen cell_traffic_gen_chk #(.N_PORTS(N_PORTS), .CNT_W(CNT_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .burst_mode (burst_mode),
  .arr_thr    (arr_thr),
  .min_burst  (min_burst),
  .cell_vld   (cell_vld),
  .cell_dst   (cell_dst),
  .lfsr_q     (lfsr_q)
);

// File: tb/test_cell_traffic_gen.sv
module test_cell_traffic_gen;
  localparam int NP = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        burst_mode, hot_en;
  logic [15:0] arr_thr, on_thr, off_thr, hot_thr;
  logic [7:0]  min_burst;
  logic [2:0]  hot_port;
  logic        cell_vld;
  logic [2:0]  cell_dst;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // model state
  logic [15:0] m_r;
  bit          m_on;
  int          m_cnt;
  logic [2:0]  m_bdst;
  int          burst_cells;

  always #2.5 clk = ~clk;

  cell_traffic_gen i_cell_traffic_gen (
    .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .hot_en(hot_en),
    .arr_thr(arr_thr), .on_thr(on_thr), .off_thr(off_thr),
    .min_burst(min_burst), .hot_port(hot_port), .hot_thr(hot_thr),
    .cell_vld(cell_vld), .cell_dst(cell_dst)
  );

  function automatic logic [15:0] step(input logic [15:0] r);
    return {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
  endfunction

  function automatic logic [2:0] choose(input logic [15:0] r);
    logic [15:0] sw;
    sw = {r[7:0], r[15:8]};
    if (hot_en && sw < hot_thr) return hot_port;
    return 3'(r[15:8] % NP);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check(cell_vld == 1'b0, "R1 vld in reset", cell_vld, 0);
    check(cell_dst == 3'd0, "R1 dst in reset", cell_dst, 0);
    m_r = 16'hACE1; m_on = 0; m_cnt = 0; m_bdst = 0;
    rst_n = 1'b1;
  endtask

  task automatic run(input int slots, input string tv, input string td);
    bit         ev;
    logic [2:0] ed;
    for (int i = 0; i < slots; i++) begin
      @(posedge clk);
      ev = 0; ed = 0;
      if (!burst_mode) begin
        if (m_r < arr_thr) begin ev = 1; ed = choose(m_r); end
      end else if (!m_on) begin
        if (m_r < on_thr) begin
          ev = 1; ed = choose(m_r); m_bdst = ed; m_on = 1; m_cnt = 1;
        end
      end else begin
        if (m_cnt >= int'(min_burst) && m_r < off_thr) begin
          m_on = 0; m_cnt = 0;
        end else begin
          ev = 1; ed = m_bdst; if (m_cnt < 255) m_cnt++;
        end
      end
      m_r = step(m_r);
      @(negedge clk);
      check(cell_vld == ev, tv, cell_vld, ev);
      check(cell_dst == ed, td, cell_dst, ed);
      if (ev) burst_cells++;
    end
  endtask

  task automatic cfg(input bit bm, input bit he, input logic [15:0] a, input logic [15:0] on,
                     input logic [15:0] off, input logic [7:0] mb, input logic [2:0] hp,
                     input logic [15:0] ht);
    burst_mode = bm; hot_en = he; arr_thr = a; on_thr = on; off_thr = off;
    min_burst = mb; hot_port = hp; hot_thr = ht;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    cfg(0, 0, 16'h8000, 0, 0, 0, 0, 0);
    do_reset();
    // R2 R3 R5: mid-rate memoryless arrivals, uniform ports
    run(1500, "R3 bernoulli vld (R2 sequence)", "R5 uniform dst");
    // R1: reseed gives same sequence again
    do_reset();
    run(300, "R1 repeat vld", "R1 repeat dst");
    // R6: skewed destinations
    cfg(0, 1, 16'h8000, 0, 0, 0, 3'd5, 16'h4000);
    do_reset();
    run(1500, "R3 bernoulli vld", "R6 hot dst");
    // R10: zero arrival threshold, burst knobs set wide open
    cfg(0, 0, 16'h0000, 16'hFFFF, 16'h0000, 8'd200, 0, 0);
    do_reset();
    burst_cells = 0;
    run(800, "R10 no cells", "R4 idle dst");
    check(burst_cells == 0, "R10 cell count", burst_cells, 0);
    // R6: near-certain arrivals and hot port
    cfg(0, 1, 16'hFFFF, 0, 0, 0, 3'd2, 16'hFFFF);
    do_reset();
    run(800, "R3 saturated vld", "R6 saturated hot dst");
    // R7 R8 R9: bursts with long minimum
    cfg(1, 0, 0, 16'h2000, 16'h4000, 8'd6, 0, 0);
    do_reset();
    run(3000, "R7 R9 burst vld", "R8 burst dst");
    // R9: zero minimum, near-certain exit -> single-cell bursts
    cfg(1, 1, 0, 16'h8000, 16'hFFFF, 8'd0, 3'd7, 16'h3000);
    do_reset();
    run(2000, "R9 min0 vld", "R7 hot entry dst");
    // mixed random configurations
    for (int k = 0; k < 6; k++) begin
      cfg(1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
          8'($urandom_range(0, 12)), 3'($urandom), 16'($urandom));
      do_reset();
      run(1500, "R3 R7 R9 random vld", "R5 R6 R8 random dst");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule